// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block sits on a microprocessor-style bus and offers three 8-bit ports to the outside world. Ports A and B are byte-wide. Port C is split into an upper and a lower nibble. The host addresses a port or the control register with a chip select, a two-bit address and active-low read and write strobes. These strobes are sampled on the system clock, so a read or write takes effect on the clock edge after the strobe falls. Every pad is modelled as three signals: an input, an output value and an output enable.

Writing to the control register does one of two things. A word with bit 7 set programs the direction and operating mode of both groups. A word with bit 7 clear changes a single port C bit. In simple mode a port is either a latched output or a live input. In strobed mode, ports A and B exchange bytes with a peripheral through handshake lines on port C and can raise interrupt requests. The port C lines that the handshake does not use keep working as plain I/O.

Top module: `pport_ctrl`

## Requirements
- R1: Address 00 selects port A, 01 port B, 10 port C and 11 the control register. While cs_n is high, writes change nothing and dout is 0x00.
- R2: A read at address 11 returns 0x00 whatever was written.
- R3: After reset every port is an input (pa_oe, pb_oe and pc_oe all zero) and both groups are in simple mode.
- R4: A control write with bit 7 set is a mode word. Its fields are: D6:D5 group A mode (01 strobed, any other value simple), D4 port A direction, D3 upper port C direction, D2 group B mode (1 strobed), D1 port B direction, D0 lower port C direction. For every direction bit, 1 means input. An output port drives all of its enables high. A mode word clears the port output latches, the buffer flags and the interrupt enables.
- R5: In simple mode an output port holds the last byte written to it. A read of an input port returns its pins as they are at the time of the read.
- R6: A control write with bit 7 clear sets port C bit D3:D1 to the value of D0. The other port C bits and the directions of ports A and B do not change.
- R7: Strobed input: a falling edge on the strobe line (PC4 for A, PC2 for B) latches the port pins and sets the buffer-full flag (PC5 for A, PC1 for B). A read of the port returns the latched byte and clears the flag.
- R8: The input interrupt line (PC3 for A, PC0 for B) is high exactly when the strobe line is high, the buffer-full flag is set and the interrupt enable is set. It therefore falls with the read that empties the buffer.
- R9: Strobed output: a host write drives the active-low buffer-full line (PC7 for A, PC1 for B) low. A falling edge on the acknowledge line (PC6 for A, PC2 for B) drives it high again. The interrupt line is high exactly when the buffer-full line is high, the acknowledge line is high and the interrupt enable is set, so it falls on the host write.
- R10: The interrupt enables are written with bit set/reset words. Bit 4 controls port A input, bit 6 controls port A output and bit 2 controls port B. With the enable clear, no interrupt is raised.
- R11: In strobed mode, a port C read returns the handshake flags at the handshake output positions and the interrupt enable at the strobe or acknowledge position. The remaining port C bits behave as in simple mode.
- R12: If a strobe edge meets a read of the same port in one cycle, the new byte is latched and buffer-full stays set. If an acknowledge edge meets a write of the same port in one cycle, the output buffer-full line stays low.
- R13: Strobe and acknowledge lines pass through two synchronizing flops. A falling line acts on the third rising clock edge after it falls, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Port / control register select |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, 0x00 when not reading |
| pa_in | input | 8 | Port A pad inputs |
| pa_out | output | 8 | Port A pad output values |
| pa_oe | output | 8 | Port A pad output enables |
| pb_in | input | 8 | Port B pad inputs |
| pb_out | output | 8 | Port B pad output values |
| pb_oe | output | 8 | Port B pad output enables |
| pc_in | input | 8 | Port C pad inputs |
| pc_out | output | 8 | Port C pad output values |
| pc_oe | output | 8 | Port C pad output enables |

## Verification
A peripheral strobe edge and a host read of the same port can land on the same clock edge. The same is true of an acknowledge edge and a host write. The bench provokes both cases by lowering the handshake line and then starting the host access exactly two clock cycles later, so that the synchronized edge and the bus strobe act on the same edge. It then judges the outcome in three ways: the read must still return the old byte, buffer-full must remain set (or the output buffer-full line must remain low), and a following read must return the newly strobed byte.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int PP_W   = 8;
    localparam int PP_NIB = PP_W / 2;

    // Handshake positions on port C (decoded by the peripheral side)
    localparam int B_INTR_BIT = 0;
    localparam int B_BUF_BIT  = 1;
    localparam int B_LINE_BIT = 2;
    localparam int A_INTR_BIT = 3;
    localparam int A_STB_BIT  = 4;
    localparam int A_IBF_BIT  = 5;
    localparam int A_ACK_BIT  = 6;
    localparam int A_OBF_BIT  = 7;

    // Synchronizer lane order
    localparam int SY_B    = 0;
    localparam int SY_ASTB = 1;
    localparam int SY_AACK = 2;
    localparam int SY_N    = 3;

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } pport_sel_e;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } pport_cfg_t;

    localparam pport_cfg_t PPORT_CFG_RST = '{
        a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
        b_mode: 1'b0,  b_in: 1'b1, cl_in: 1'b1
    };

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{s1: '1, s2: '1, s3: '1};
        else     st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_lane
        assign lvl[i]  = st_q.s2[i];
        assign fall[i] = st_q.s3[i] & ~st_q.s2[i];
    end
endmodule

// File: rtl/pport_host.sv
module pport_host (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic [1:0] addr,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic [3:0] wr_sel,
    output logic [1:0] rd_sel
);
    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } host_t;

    host_t hs_d, hs_q;
    logic  wr_fall, rd_fall;

    always_comb begin
        hs_d         = hs_q;
        hs_d.rd_prev = rd_n | cs_n;
        hs_d.wr_prev = wr_n | cs_n;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) hs_q <= '{rd_prev: 1'b1, wr_prev: 1'b1};
        else     hs_q <= hs_d;
    end

    assign wr_fall = hs_q.wr_prev & ~wr_n & ~cs_n;
    assign rd_fall = hs_q.rd_prev & ~rd_n & ~cs_n;

    for (genvar i = 0; i < 4; i++) begin : g_wr
        assign wr_sel[i] = wr_fall & (addr == 2'(i));
    end
    for (genvar j = 0; j < 2; j++) begin : g_rd
        assign rd_sel[j] = rd_fall & (addr == 2'(j));
    end
endmodule

// File: rtl/pport_hs.sv
module pport_hs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hs_en,
    input  logic         is_in,
    input  logic [W-1:0] pin_data,
    input  logic [W-1:0] host_wdata,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic         line_fall,
    input  logic         line_lvl,
    input  logic         inte_in_set,
    input  logic         inte_out_set,
    input  logic         inte_val,
    output logic [W-1:0] lat,
    output logic         ibf,
    output logic         obf_n,
    output logic         intr,
    output logic         inte_in,
    output logic         inte_out
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic         ibf;
        logic         obf_n;
        logic         intr;
        logic         inte_in;
        logic         inte_out;
    } chan_t;

    localparam chan_t CHAN_RST = '{lat: '0, ibf: 1'b0, obf_n: 1'b1,
                                   intr: 1'b0, inte_in: 1'b0, inte_out: 1'b0};

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (host_wr && !is_in) ch_d.lat = host_wdata;
        if (hs_en && is_in) begin
            // a new strobe beats a concurrent read
            if (line_fall) begin
                ch_d.lat = pin_data;
                ch_d.ibf = 1'b1;
            end else if (host_rd) begin
                ch_d.ibf = 1'b0;
            end
        end
        if (hs_en && !is_in) begin
            // a new write beats a concurrent acknowledge
            if (host_wr)        ch_d.obf_n = 1'b0;
            else if (line_fall) ch_d.obf_n = 1'b1;
        end
        if (inte_in_set)  ch_d.inte_in  = inte_val;
        if (inte_out_set) ch_d.inte_out = inte_val;
        if (clr) ch_d = CHAN_RST;
        ch_d.intr = hs_en & (is_in ? (ch_d.inte_in & ch_d.ibf & line_lvl)
                                   : (ch_d.inte_out & ch_d.obf_n & line_lvl));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ch_q <= CHAN_RST;
        else     ch_q <= ch_d;
    end

    assign lat      = ch_q.lat;
    assign ibf      = ch_q.ibf;
    assign obf_n    = ch_q.obf_n;
    assign intr     = ch_q.intr;
    assign inte_in  = ch_q.inte_in;
    assign inte_out = ch_q.inte_out;
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic [1:0]      addr,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [PP_W-1:0] din,
    output logic [PP_W-1:0] dout,
    input  logic [PP_W-1:0] pa_in,
    output logic [PP_W-1:0] pa_out,
    output logic [PP_W-1:0] pa_oe,
    input  logic [PP_W-1:0] pb_in,
    output logic [PP_W-1:0] pb_out,
    output logic [PP_W-1:0] pb_oe,
    input  logic [PP_W-1:0] pc_in,
    output logic [PP_W-1:0] pc_out,
    output logic [PP_W-1:0] pc_oe
);
    typedef struct packed {
        pport_cfg_t      cfg;
        logic [PP_W-1:0] pc_lat;
    } top_t;

    top_t tp_d, tp_q;

    logic [3:0]      wr_sel;
    logic [1:0]      rd_sel;
    logic            mode_wr, bsr_wr;
    logic            a_m1, a_m1_in, a_m1_out, b_m1;
    logic [SY_N-1:0] sy_raw, sy_lvl, sy_fall;
    logic [PP_W-1:0] a_lat, b_lat;
    logic            a_ibf, a_obf_n, a_intr, a_ie_in, a_ie_out;
    logic            b_ibf, b_obf_n, b_intr, b_ie_in, b_ie_out;
    logic            a_line_fall, a_line_lvl;
    logic [PP_W-1:0] base_oe, pc_rd;

    pport_host u_host (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    assign mode_wr = wr_sel[SEL_CTL] & din[7];
    assign bsr_wr  = wr_sel[SEL_CTL] & ~din[7];

    assign a_m1     = (tp_q.cfg.a_mode == 2'b01);
    assign a_m1_in  = a_m1 & tp_q.cfg.a_in;
    assign a_m1_out = a_m1 & ~tp_q.cfg.a_in;
    assign b_m1     = tp_q.cfg.b_mode;

    always_comb begin
        tp_d = tp_q;
        if (mode_wr) begin
            tp_d.cfg.a_mode = din[6:5];
            tp_d.cfg.a_in   = din[4];
            tp_d.cfg.cu_in  = din[3];
            tp_d.cfg.b_mode = din[2];
            tp_d.cfg.b_in   = din[1];
            tp_d.cfg.cl_in  = din[0];
            tp_d.pc_lat     = '0;
        end else if (bsr_wr) begin
            tp_d.pc_lat[din[3:1]] = din[0];
        end else if (wr_sel[SEL_C]) begin
            tp_d.pc_lat = din;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) tp_q <= '{cfg: PPORT_CFG_RST, pc_lat: '0};
        else     tp_q <= tp_d;
    end

    // handshake line synchronizers
    assign sy_raw[SY_B]    = pc_in[B_LINE_BIT];
    assign sy_raw[SY_ASTB] = pc_in[A_STB_BIT];
    assign sy_raw[SY_AACK] = pc_in[A_ACK_BIT];

    pport_sync #(.N(SY_N)) u_sync (
        .clk(clk), .rst(rst), .raw(sy_raw), .lvl(sy_lvl), .fall(sy_fall)
    );

    assign a_line_fall = tp_q.cfg.a_in ? sy_fall[SY_ASTB] : sy_fall[SY_AACK];
    assign a_line_lvl  = tp_q.cfg.a_in ? sy_lvl[SY_ASTB]  : sy_lvl[SY_AACK];

    pport_hs #(.W(PP_W)) u_chan_a (
        .clk(clk), .rst(rst), .clr(mode_wr), .hs_en(a_m1), .is_in(tp_q.cfg.a_in),
        .pin_data(pa_in), .host_wdata(din), .host_wr(wr_sel[SEL_A]), .host_rd(rd_sel[SEL_A]),
        .line_fall(a_line_fall), .line_lvl(a_line_lvl),
        .inte_in_set(bsr_wr && din[3:1] == 3'(A_STB_BIT)),
        .inte_out_set(bsr_wr && din[3:1] == 3'(A_ACK_BIT)),
        .inte_val(din[0]),
        .lat(a_lat), .ibf(a_ibf), .obf_n(a_obf_n), .intr(a_intr),
        .inte_in(a_ie_in), .inte_out(a_ie_out)
    );

    pport_hs #(.W(PP_W)) u_chan_b (
        .clk(clk), .rst(rst), .clr(mode_wr), .hs_en(b_m1), .is_in(tp_q.cfg.b_in),
        .pin_data(pb_in), .host_wdata(din), .host_wr(wr_sel[SEL_B]), .host_rd(rd_sel[SEL_B]),
        .line_fall(sy_fall[SY_B]), .line_lvl(sy_lvl[SY_B]),
        .inte_in_set(bsr_wr && din[3:1] == 3'(B_LINE_BIT)),
        .inte_out_set(bsr_wr && din[3:1] == 3'(B_LINE_BIT)),
        .inte_val(din[0]),
        .lat(b_lat), .ibf(b_ibf), .obf_n(b_obf_n), .intr(b_intr),
        .inte_in(b_ie_in), .inte_out(b_ie_out)
    );

    // port C lane assignment: plain nibbles first, handshake overrides
    assign base_oe = {{PP_NIB{~tp_q.cfg.cu_in}}, {PP_NIB{~tp_q.cfg.cl_in}}};

    always_comb begin
        pc_out = tp_q.pc_lat;
        pc_oe  = base_oe;
        pc_rd  = (tp_q.pc_lat & base_oe) | (pc_in & ~base_oe);
        if (a_m1_in) begin
            pc_out[A_INTR_BIT] = a_intr;   pc_oe[A_INTR_BIT] = 1'b1; pc_rd[A_INTR_BIT] = a_intr;
            pc_out[A_IBF_BIT]  = a_ibf;    pc_oe[A_IBF_BIT]  = 1'b1; pc_rd[A_IBF_BIT]  = a_ibf;
            pc_oe[A_STB_BIT]   = 1'b0;     pc_rd[A_STB_BIT]  = a_ie_in;
        end
        if (a_m1_out) begin
            pc_out[A_INTR_BIT] = a_intr;   pc_oe[A_INTR_BIT] = 1'b1; pc_rd[A_INTR_BIT] = a_intr;
            pc_out[A_OBF_BIT]  = a_obf_n;  pc_oe[A_OBF_BIT]  = 1'b1; pc_rd[A_OBF_BIT]  = a_obf_n;
            pc_oe[A_ACK_BIT]   = 1'b0;     pc_rd[A_ACK_BIT]  = a_ie_out;
        end
        if (b_m1) begin
            pc_out[B_INTR_BIT] = b_intr;   pc_oe[B_INTR_BIT] = 1'b1; pc_rd[B_INTR_BIT] = b_intr;
            pc_out[B_BUF_BIT]  = tp_q.cfg.b_in ? b_ibf : b_obf_n;
            pc_oe[B_BUF_BIT]   = 1'b1;
            pc_rd[B_BUF_BIT]   = tp_q.cfg.b_in ? b_ibf : b_obf_n;
            pc_oe[B_LINE_BIT]  = 1'b0;
            pc_rd[B_LINE_BIT]  = tp_q.cfg.b_in ? b_ie_in : b_ie_out;
        end
    end

    always_comb begin
        dout = '0;
        if (!cs_n && !rd_n) begin
            case (pport_sel_e'(addr))
                SEL_A:   dout = (tp_q.cfg.a_in && !a_m1) ? pa_in : a_lat;
                SEL_B:   dout = (tp_q.cfg.b_in && !b_m1) ? pb_in : b_lat;
                SEL_C:   dout = pc_rd;
                default: dout = '0;
            endcase
        end
    end

    assign pa_out = a_lat;
    assign pa_oe  = {PP_W{~tp_q.cfg.a_in}};
    assign pb_out = b_lat;
    assign pb_oe  = {PP_W{~tp_q.cfg.b_in}};
endmodule

// File: rtl/pport_chk.sv
module pport_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic [1:0] addr,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ctl_kind,
    input logic [7:0] dout,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_oe,
    input logic       pc_intr_a,
    input logic       pc_ibf_a,
    input logic       pc_obf_a,
    input logic       a_m1_in,
    input logic       a_m1_out
);
    // R2
    ctl_noread_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && addr == 2'b11) |-> dout == 8'h00);

    // R3
    rst_inputs_chk: assert property (@(posedge clk)
        rst |=> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00));

    // R4
    pa_oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == 8'h00 || pa_oe == 8'hFF));

    // R6
    bsr_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && $past(wr_n) && addr == 2'b11 && !ctl_kind)
        |=> ($stable(pa_oe) && $stable(pb_oe)));

    // R8
    a_intr_needs_ibf_chk: assert property (@(posedge clk) disable iff (rst)
        (a_m1_in && pc_intr_a) |-> pc_ibf_a);

    // R9
    a_obf_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        (a_m1_out && $past(a_m1_out) && $fell(pc_obf_a))
        |-> $past(!cs_n && !wr_n && addr == 2'b00));
endmodule

bind pport_ctrl pport_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .ctl_kind(din[7]), .dout(dout), .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
    .pc_intr_a(pc_out[3]), .pc_ibf_a(pc_out[5]), .pc_obf_a(pc_out[7]),
    .a_m1_in(a_m1_in), .a_m1_out(a_m1_out)
);

// File: tb/tb_pport_ctrl.sv
module tb_pport_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_chk = 0;
    int n_err = 0;

    pport_ctrl dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; addr = a; din = v; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
        #1 v = dout;
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic line_low(input int b);
        @(negedge clk); pc_in[b] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic line_high(input int b);
        pc_in[b] = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R3 pa_oe", pa_oe, 8'h00);
        chk("R3 pb_oe", pb_oe, 8'h00);
        chk("R3 pc_oe", pc_oe, 8'h00);
        host_rd(2'b11, v);
        chk("R2 ctl read after reset", v, 8'h00);
    endtask

    task automatic t_simple;
        logic [7:0] v;
        host_wr(2'b11, 8'h98);               // A in, CU in, B out, CL out
        chk("R4 pa_oe", pa_oe, 8'h00);
        chk("R4 pb_oe", pb_oe, 8'hFF);
        chk("R4 pc_oe", pc_oe, 8'h0F);
        host_wr(2'b01, 8'h5A);
        chk("R5 port B latch", pb_out, 8'h5A);
        pa_in = 8'h33;
        host_rd(2'b00, v);
        chk("R5 port A live 1", v, 8'h33);
        pa_in = 8'hC4;
        host_rd(2'b00, v);
        chk("R5 port A live 2", v, 8'hC4);
        host_wr(2'b10, 8'hA5);
        chk("R5 port C latch", pc_out, 8'hA5);
        pc_in = 8'h70;
        host_rd(2'b10, v);
        chk("R11 port C mixed read", v, 8'h75);
        @(negedge clk); cs_n = 1'b1; addr = 2'b01; din = 8'hFF; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        chk("R1 deselected write", pb_out, 8'h5A);
        @(negedge clk); addr = 2'b01; rd_n = 1'b0;
        #1 chk("R1 deselected dout", dout, 8'h00);
        @(negedge clk); rd_n = 1'b1;
        host_rd(2'b11, v);
        chk("R2 ctl read", v, 8'h00);
    endtask

    task automatic t_bitset;
        host_wr(2'b11, 8'h03);               // bit 1 <- 1
        chk("R6 set bit1", pc_out, 8'hA7);
        host_wr(2'b11, 8'h00);               // bit 0 <- 0
        chk("R6 clear bit0", pc_out, 8'hA6);
        chk("R6 pa_oe kept", pa_oe, 8'h00);
        chk("R6 pb_oe kept", pb_oe, 8'hFF);
    endtask

    task automatic t_strobed_in;
        logic [7:0] v;
        pc_in = 8'hFF;
        repeat (3) @(negedge clk);
        host_wr(2'b11, 8'hB6);               // A strobed in, B strobed in, CU out
        chk("R4 pc_oe strobed in", pc_oe, 8'hEB);
        chk("R4 latches cleared", pc_out & 8'hC0, 8'h00);
        host_wr(2'b11, 8'h09);               // enable A input interrupt (bit 4)
        pa_in = 8'h3C;
        @(negedge clk); pc_in[4] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 not yet", {7'd0, pc_out[5]}, 8'h00);
        @(negedge clk);
        chk("R7 ibf set", {7'd0, pc_out[5]}, 8'h01);
        pa_in = 8'h00;
        line_high(4);
        chk("R8 intr raised", {7'd0, pc_out[3]}, 8'h01);
        host_rd(2'b10, v);
        chk("R11 R10 port C status", v, 8'h38);
        host_rd(2'b00, v);
        chk("R7 latched byte", v, 8'h3C);
        chk("R7 ibf cleared", {7'd0, pc_out[5]}, 8'h00);
        chk("R8 intr cleared", {7'd0, pc_out[3]}, 8'h00);
        pb_in = 8'h81;
        line_low(2);
        chk("R7 port B ibf", {7'd0, pc_out[1]}, 8'h01);
        line_high(2);
        chk("R10 port B no intr", {7'd0, pc_out[0]}, 8'h00);
        host_rd(2'b01, v);
        chk("R7 port B byte", v, 8'h81);
    endtask

    task automatic t_clash_in;
        logic [7:0] v;
        pa_in = 8'h11;
        line_low(4);
        line_high(4);
        @(negedge clk); pa_in = 8'h22; pc_in[4] = 1'b0;
        @(negedge clk);
        @(negedge clk); cs_n = 1'b0; addr = 2'b00; rd_n = 1'b1; rd_n = 1'b0;
        #1 v = dout;
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1; pc_in[4] = 1'b1;
        chk("R12 read sees old byte", v, 8'h11);
        chk("R12 ibf kept", {7'd0, pc_out[5]}, 8'h01);
        repeat (4) @(negedge clk);
        host_rd(2'b00, v);
        chk("R12 new byte latched", v, 8'h22);
    endtask

    task automatic t_strobed_out;
        host_wr(2'b11, 8'hAC);               // A strobed out, B strobed out, CU in
        chk("R4 pc_oe strobed out", pc_oe, 8'h8B);
        chk("R9 obf idle", {6'd0, pc_out[7], pc_out[1]}, 8'h03);
        host_wr(2'b11, 8'h0D);               // enable A output interrupt (bit 6)
        chk("R10 intr with enable", {7'd0, pc_out[3]}, 8'h01);
        host_wr(2'b00, 8'h96);
        chk("R9 data out", pa_out, 8'h96);
        chk("R9 obf low", {7'd0, pc_out[7]}, 8'h00);
        chk("R9 intr dropped", {7'd0, pc_out[3]}, 8'h00);
        line_low(6);
        chk("R9 obf released", {7'd0, pc_out[7]}, 8'h01);
        chk("R9 intr waits ack high", {7'd0, pc_out[3]}, 8'h00);
        line_high(6);
        chk("R9 intr raised", {7'd0, pc_out[3]}, 8'h01);
        host_wr(2'b01, 8'h42);
        chk("R9 port B data", pb_out, 8'h42);
        chk("R9 port B obf low", {7'd0, pc_out[1]}, 8'h00);
        line_low(2);
        line_high(2);
        chk("R9 port B obf high", {7'd0, pc_out[1]}, 8'h01);
        chk("R10 port B no intr", {7'd0, pc_out[0]}, 8'h00);
    endtask

    task automatic t_clash_out;
        @(negedge clk); pc_in[6] = 1'b0;
        @(negedge clk);
        @(negedge clk); cs_n = 1'b0; addr = 2'b00; din = 8'h02; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1; pc_in[6] = 1'b1;
        chk("R12 obf kept low", {7'd0, pc_out[7]}, 8'h00);
        chk("R12 new data", pa_out, 8'h02);
    endtask

    task automatic t_group_a_other;
        host_wr(2'b11, 8'hC0);               // D6 set: group A stays simple
        chk("R4 pa_oe simple", pa_oe, 8'hFF);
        chk("R4 pc_oe all out", pc_oe, 8'hFF);
        chk("R4 pc latch cleared", pc_out, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_simple();
        t_bitset();
        t_strobed_in();
        t_clash_in();
        t_strobed_out();
        t_clash_out();
        t_group_a_other();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule